// File: doc/BRIEF.md
# ADC power and channel sequencer

This block controls an external two-channel ADC through two lines: a power-down line and a one-hot channel-select bus. When it is enabled, it releases power-down and waits for a programmable settling delay. It then selects each channel in turn and holds each select until the converter returns a data-valid strobe.

There are three operating modes. In normal mode the block scans the channels continuously while the converter stays powered. In low-power mode the block powers the converter down after each scan. It sleeps for a programmable number of cycles of up to 24 bits, then repeats the power-up delay and the scan. In one-shot mode the block scans once, gives a single-cycle done pulse, and stays powered down until its enable is dropped and raised again.

A software reset input holds the sequencer idle for as long as it is set. All outputs are registered.

Top module: `adc_pwr_seq`

## Requirements
- R1: Out of reset, `adc_pd` is 1, `adc_chn_sel` is 0 and `oneshot_done` is 0.
- R2: The first channel select rises exactly `pwrup_time + 2` clock cycles after the clock edge on which `adc_pd` falls. `pwrup_time` is 4 bits wide, 0 to 15.
- R3: Channels are selected in ascending order, with bit 0 of `adc_chn_sel` first. Each select is held unchanged until `data_valid` is sampled high on a clock edge. On that edge the next channel is selected.
- R4: `adc_chn_sel` is one-hot or all-zero in every cycle.
- R5: In normal mode (`lp_mode`=0 and `oneshot_mode`=0), the edge that samples `data_valid` for the last channel selects channel 0 again, and `adc_pd` stays 0.
- R6: In low-power mode (`lp_mode`=1 and `oneshot_mode`=0), the edge that samples `data_valid` for the last channel clears `adc_chn_sel` and sets `adc_pd` together.
- R7: In low-power mode, `adc_pd` then stays 1 for exactly `wakeup_time` cycles. `wakeup_time` is 24 bits wide, and the value 0 acts as 1. After that, `adc_pd` falls and the R2 power-up delay applies again.
- R8: In one-shot mode (`oneshot_mode`=1, which takes priority over `lp_mode`), the edge that samples `data_valid` for the last channel clears the select, sets `adc_pd` and raises `oneshot_done` for exactly one cycle. The block then stays powered down with no select until `enable` has been low and is raised again.
- R9: If `enable` is sampled low, the next cycle has `adc_pd`=1 and `adc_chn_sel`=0.
- R10: While `sw_reset` is sampled high, the next cycle has `adc_pd`=1 and `adc_chn_sel`=0 whatever `enable` is. The first edge that samples `sw_reset` low with `enable` high clears `adc_pd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable |
| lp_mode | input | 1 | Low-power duty-cycling mode select |
| oneshot_mode | input | 1 | Single-scan mode select |
| sw_reset | input | 1 | Software reset, holds the sequencer idle while 1 |
| pwrup_time | input | 4 | Power-up settling delay |
| wakeup_time | input | 24 | Low-power sleep interval in cycles |
| data_valid | input | 1 | Conversion complete strobe from the ADC |
| adc_pd | output | 1 | Power-down line to the ADC |
| adc_chn_sel | output | 2 | One-hot channel select to the ADC |
| oneshot_done | output | 1 | One-cycle pulse at the end of a one-shot scan |

## Verification
Most wrong internal states in this block show up at the ports within one or two cycles. A miscounted timer shows up directly in the gap between the fall of `adc_pd` and the first select, which should be the power-up delay plus two. In low-power mode it also shows up in the length of the `adc_pd` high pulse, which should be the sleep interval. A wrong state after the last channel shows up on the very next edge: the select does not wrap, `adc_pd` does not rise, or the done pulse is missing or lasts too long. Enable and software-reset faults show up one cycle after the input changes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SCAN,
    ST_SLEEP,
    ST_DONE
  } seq_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (!(&count)) count <= count + 1'b1;
  end
endmodule

// File: rtl/adc_seq_chsel.sv
module adc_seq_chsel #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           load_first,
  input  logic           advance,
  output logic [NCH-1:0] sel,
  output logic           at_last
);
  localparam logic [NCH-1:0] FIRST = NCH'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) sel <= '0;
    else if (load_first) sel <= FIRST;
    else if (advance) sel <= sel << 1;
  end

  assign at_last = sel[NCH-1];
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int PU_W = 4,
  parameter int WK_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            lp_mode,
  input  logic            oneshot_mode,
  input  logic            sw_reset,
  input  logic [PU_W-1:0] pwrup_time,
  input  logic [WK_W-1:0] wakeup_time,
  input  logic            data_valid,
  output logic            adc_pd,
  output logic [NCH-1:0]  adc_chn_sel,
  output logic            oneshot_done
);
  localparam int CW = imax(WK_W, PU_W + 1);

  seq_state_e     state_q, state_d;
  logic [CW-1:0]  cnt;
  logic           tmr_clr, sel_clr, sel_first, sel_adv, at_last;
  logic           pd_d, done_d;
  logic [CW:0]    cnt_plus1, wake_ext, pu_target;

  assign cnt_plus1 = {1'b0, cnt} + 1'b1;
  assign wake_ext  = (CW+1)'(wakeup_time);
  assign pu_target = (CW+1)'(pwrup_time) + 1'b1;

  adc_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .count(cnt)
  );

  adc_seq_chsel #(.NCH(NCH)) u_chsel (
    .clk(clk), .rst(rst), .clr(sel_clr), .load_first(sel_first),
    .advance(sel_adv), .sel(adc_chn_sel), .at_last(at_last)
  );

  always_comb begin
    state_d   = state_q;
    sel_clr   = 1'b0;
    sel_first = 1'b0;
    sel_adv   = 1'b0;
    pd_d      = adc_pd;
    done_d    = 1'b0;
    if (sw_reset || !enable) begin
      state_d = ST_IDLE;
      sel_clr = 1'b1;
      pd_d    = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_d = ST_PWRUP;
          pd_d    = 1'b0;
        end
        ST_PWRUP: begin
          if ({1'b0, cnt} == pu_target) begin
            state_d   = ST_SCAN;
            sel_first = 1'b1;
          end
        end
        ST_SCAN: begin
          if (data_valid) begin
            if (!at_last) begin
              sel_adv = 1'b1;
            end else if (oneshot_mode) begin
              state_d = ST_DONE;
              sel_clr = 1'b1;
              pd_d    = 1'b1;
              done_d  = 1'b1;
            end else if (lp_mode) begin
              state_d = ST_SLEEP;
              sel_clr = 1'b1;
              pd_d    = 1'b1;
            end else begin
              sel_first = 1'b1;
            end
          end
        end
        ST_SLEEP: begin
          if (cnt_plus1 >= wake_ext) begin
            state_d = ST_PWRUP;
            pd_d    = 1'b0;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      adc_pd       <= 1'b1;
      oneshot_done <= 1'b0;
    end else begin
      state_q      <= state_d;
      adc_pd       <= pd_d;
      oneshot_done <= done_d;
    end
  end

  // Cycle-age counters used only by the checks below
  logic [CW:0] pu_age, slp_age;
  always_ff @(posedge clk) begin
    if (rst) begin
      pu_age  <= '0;
      slp_age <= '0;
    end else begin
      if (adc_pd) pu_age <= '0;
      else if (!(&pu_age)) pu_age <= pu_age + 1'b1;
      if (!adc_pd) slp_age <= '0;
      else if (!(&slp_age)) slp_age <= slp_age + 1'b1;
    end
  end

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(adc_chn_sel));

  // R2
  pwrup_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|adc_chn_sel) |-> (pu_age == (CW+1)'(pwrup_time) + 2));

  // R7
  sleep_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_pd) && $past(state_q) == ST_SLEEP) |->
      (slp_age == ((wakeup_time == '0) ? (CW+1)'(1) : wake_ext)));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((|adc_chn_sel) && !data_valid && enable && !sw_reset) |=> $stable(adc_chn_sel));

  // R9
  disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable || sw_reset) |=> (adc_pd && adc_chn_sel == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    oneshot_done |-> (adc_pd && adc_chn_sel == '0) ##1 !oneshot_done);
endmodule

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, lp_mode = 1'b0, oneshot_mode = 1'b0, sw_reset = 1'b0;
  logic [3:0]  pwrup_time = '0;
  logic [23:0] wakeup_time = '0;
  logic        data_valid = 1'b0;
  logic        adc_pd;
  logic [1:0]  adc_chn_sel;
  logic        oneshot_done;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_pwr_seq u0 (
    .clk(clk), .rst(rst), .enable(enable), .lp_mode(lp_mode),
    .oneshot_mode(oneshot_mode), .sw_reset(sw_reset), .pwrup_time(pwrup_time),
    .wakeup_time(wakeup_time), .data_valid(data_valid), .adc_pd(adc_pd),
    .adc_chn_sel(adc_chn_sel), .oneshot_done(oneshot_done)
  );

  typedef struct packed {
    logic        lp;
    logic        os;
    logic [3:0]  pu;
    logic [23:0] wk;
    logic [3:0]  hold;
    logic [7:0]  exp_pu;
    logic [23:0] exp_slp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 4'd0,  24'd0,   4'd0, 8'd2,  24'd0},
    '{1'b0, 1'b0, 4'd15, 24'd9,   4'd3, 8'd17, 24'd0},
    '{1'b1, 1'b0, 4'd3,  24'd5,   4'd0, 8'd5,  24'd5},
    '{1'b1, 1'b0, 4'd7,  24'd0,   4'd2, 8'd9,  24'd1},
    '{1'b0, 1'b1, 4'd2,  24'd4,   4'd0, 8'd4,  24'd0},
    '{1'b1, 1'b1, 4'd1,  24'd30,  4'd1, 8'd3,  24'd0},
    '{1'b1, 1'b0, 4'd0,  24'd150, 4'd0, 8'd2,  24'd150}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pd_low(output int n);
    n = 0;
    while (adc_pd && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic wait_sel(output int n);
    n = 0;
    while (adc_chn_sel == 2'b00 && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_dv();
    data_valid = 1'b1;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    lp_mode = v.lp; oneshot_mode = v.os; pwrup_time = v.pu; wakeup_time = v.wk;
    enable = 1'b1;
    wait_pd_low(n);
    wait_sel(n);
    chk(n == int'(v.exp_pu), "R2 pwrup latency", n, v.exp_pu);
    chk(adc_chn_sel == 2'b01, "R3 first channel", adc_chn_sel, 1);
    repeat (int'(v.hold)) @(negedge clk);
    chk(adc_chn_sel == 2'b01, "R3 hold without data_valid", adc_chn_sel, 1);
    pulse_dv();
    chk(adc_chn_sel == 2'b10, "R3 second channel", adc_chn_sel, 2);
    pulse_dv();
    if (v.os) begin
      chk(adc_pd && adc_chn_sel == 2'b00, "R8 powered down after scan", {adc_pd, adc_chn_sel}, 4);
      chk(oneshot_done == 1'b1, "R8 done pulse", oneshot_done, 1);
      @(negedge clk);
      chk(oneshot_done == 1'b0, "R8 done one cycle", oneshot_done, 0);
      repeat (20) @(negedge clk);
      chk(adc_pd && adc_chn_sel == 2'b00, "R8 stays idle", {adc_pd, adc_chn_sel}, 4);
    end else if (v.lp) begin
      chk(adc_pd && adc_chn_sel == 2'b00, "R6 power down after scan", {adc_pd, adc_chn_sel}, 4);
      wait_pd_low(n);
      chk(n == int'(v.exp_slp), "R7 sleep length", n, v.exp_slp);
      wait_sel(n);
      chk(n == int'(v.exp_pu), "R7 pwrup latency after sleep", n, v.exp_pu);
    end else begin
      chk(adc_chn_sel == 2'b01 && !adc_pd, "R5 wrap to channel 0", {adc_pd, adc_chn_sel}, 1);
    end
    enable = 1'b0;
    @(negedge clk);
    chk(adc_pd && adc_chn_sel == 2'b00, "R9 disable", {adc_pd, adc_chn_sel}, 4);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(adc_pd == 1'b1 && adc_chn_sel == 2'b00 && oneshot_done == 1'b0,
        "R1 reset state", {adc_pd, adc_chn_sel, oneshot_done}, 8);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8 re-enable after one-shot starts a new scan
    oneshot_mode = 1'b1; lp_mode = 1'b0; pwrup_time = 4'd1;
    enable = 1'b1;
    wait_pd_low(n); wait_sel(n);
    pulse_dv(); pulse_dv();
    repeat (3) @(negedge clk);
    enable = 1'b0; @(negedge clk);
    enable = 1'b1;
    wait_pd_low(n);
    wait_sel(n);
    chk(n == 3 && adc_chn_sel == 2'b01, "R8 rescan after re-enable", n, 3);
    enable = 1'b0; @(negedge clk);

    // R10 software reset mid-scan
    oneshot_mode = 1'b0; lp_mode = 1'b0; pwrup_time = 4'd0;
    enable = 1'b1;
    wait_pd_low(n); wait_sel(n);
    sw_reset = 1'b1;
    @(negedge clk);
    chk(adc_pd && adc_chn_sel == 2'b00, "R10 reset forces idle", {adc_pd, adc_chn_sel}, 4);
    repeat (6) @(negedge clk);
    chk(adc_pd && adc_chn_sel == 2'b00, "R10 held while set", {adc_pd, adc_chn_sel}, 4);
    sw_reset = 1'b0;
    @(negedge clk);
    chk(adc_pd == 1'b0, "R10 powers up after release", adc_pd, 0);
    wait_sel(n);
    chk(n == 2, "R10 R2 latency after release", n, 2);
    enable = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule